// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits in front of the arithmetic datapath of a double-precision fused multiply-add that computes `z + (x * y)`, or `z - (x * y)` when the negate-product control is set. It is purely combinational. Each of the three 64-bit operands is sorted into one of six classes: signalling NaN, quiet NaN, infinity, zero, subnormal or normal. From those classes, the operand signs, the negate-product control and the rounding mode, the block decides whether the final answer is already known.

When the answer is known, the block presents the finished 64-bit result and an invalid-operation flag. When it is not, it raises `proceed` so the mantissa datapath takes over, and it drives the result and the flag to zero. Subnormal normalisation and the real arithmetic are outside this block.

Top module: `fma_special_resolve`

## Requirements
- R1: If any operand is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 51 clear), the result is the first such operand in the order z, x, y. It is returned with fraction bit 51 set, and the invalid flag is 1.
- R2: With no signalling NaN present but at least one quiet NaN (exponent all ones, fraction bit 51 set), the result is the first quiet NaN in the order z, x, y. Its bits are unchanged and the invalid flag is 0.
- R3: With no NaN present, infinity times zero in either operand order gives the default NaN 0x7FF8000000000000, and the invalid flag is 1. This holds whatever z is.
- R4: The effective product sign is sign(x) XOR sign(y), inverted when `negProd` is 1. Sign is bit 63.
- R5: An infinite product combined with an infinite z whose sign differs from the effective product sign gives the default NaN, and the invalid flag is 1.
- R6: In every other case with an infinite product, the result is infinity (exponent all ones, fraction zero) carrying the effective product sign, and the invalid flag is 0.
- R7: A product that is zero, or finite and nonzero, combined with an infinite z returns z unchanged, and the invalid flag is 0.
- R8: A zero product with a finite nonzero z, subnormal or normal, returns z unchanged.
- R9: A zero product with a zero z that has the same sign as the effective product sign returns z unchanged.
- R10: A zero product with a zero z of the opposite sign returns zero. The sign is 1 only when `rndMode` is 2'b11 (toward minus infinity); the other codes are 2'b00 nearest, 2'b01 toward zero and 2'b10 toward plus infinity.
- R11: In every case not covered above, `proceed` is 1 and `specialValid`, `specialResult` and `invalidFlag` are all 0. `proceed` is always the complement of `specialValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| zOp | input | 64 | Addend operand |
| xOp | input | 64 | First multiplicand |
| yOp | input | 64 | Second multiplicand |
| negProd | input | 1 | 1 selects z - (x*y) |
| rndMode | input | 2 | Rounding mode code |
| specialValid | output | 1 | Result is fully decided here |
| specialResult | output | 64 | Decided result, 0 when proceeding |
| invalidFlag | output | 1 | Invalid-operation exception |
| proceed | output | 1 | Hand the operation to the datapath |

## Verification
The block holds no state, so a wrong decision shows at the ports in the same cycle that the operands are applied. A misordered NaN priority returns a NaN from the wrong operand. A missing quiet bit or sign inversion shows as a single wrong bit in the result. A wrong class decode leaks a special case into `proceed`, or blocks a normal case from reaching the datapath. Random operand mixes weighted toward special classes, together with directed sign and rounding-mode corners, compare every output against an independent reference for every vector.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;
  parameter int EXP_W = 11;
  parameter int FRAC_W = 52;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int N_OPS = 3;
  localparam int IDX_W = $clog2(N_OPS);
  localparam int QBIT = FRAC_W - 1;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_SUB  = 3'd1,
    CL_NORM = 3'd2,
    CL_INF  = 3'd3,
    CL_QNAN = 3'd4,
    CL_SNAN = 3'd5
  } fpClass_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rndMode_e;

  // Strobes from the decision logic to the result builder
  typedef struct packed {
    logic             pickOp;
    logic [IDX_W-1:0] opIdx;
    logic             quietIt;
    logic             pickDefNan;
    logic             pickInf;
    logic             infSign;
    logic             pickZero;
    logic             zeroSign;
    logic             raiseInvalid;
  } strobe_t;
endpackage

// File: rtl/fma_sc_classify.sv
module fma_sc_classify
  import fma_sc_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [EW+FW:0] opWord,
  output fpClass_e       opClass,
  output logic           opSign
);
  logic [EW-1:0] expField;
  logic [FW-1:0] fracField;
  logic expOnes, expZero, fracZero;

  assign expField  = opWord[EW+FW-1:FW];
  assign fracField = opWord[FW-1:0];
  assign expOnes   = &expField;
  assign expZero   = ~|expField;
  assign fracZero  = ~|fracField;
  assign opSign    = opWord[EW+FW];

  always_comb begin
    if (expOnes) begin
      if (fracZero)           opClass = CL_INF;
      else if (fracField[FW-1]) opClass = CL_QNAN;
      else                    opClass = CL_SNAN;
    end else if (expZero) begin
      opClass = fracZero ? CL_ZERO : CL_SUB;
    end else begin
      opClass = CL_NORM;
    end
  end
endmodule

// File: rtl/fma_sc_ctrl.sv
module fma_sc_ctrl
  import fma_sc_pkg::*;
(
  input  fpClass_e   opClass [N_OPS],
  input  logic       opSign  [N_OPS],
  input  logic       negProd,
  input  logic [1:0] rndMode,
  output strobe_t    strobe
);
  // operand index order encodes priority: 0 = z, 1 = x, 2 = y
  localparam int IZ = 0;
  localparam int IX = 1;
  localparam int IY = 2;

  logic             anySnan, anyQnan;
  logic [IDX_W-1:0] snanIdx, qnanIdx;
  logic             prodSign;
  logic             xInf, yInf, xZero, yZero, zInf, zZero;
  logic             prodInf, prodZero, infTimesZero;

  always_comb begin
    anySnan = 1'b0;
    anyQnan = 1'b0;
    snanIdx = '0;
    qnanIdx = '0;
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (opClass[i] == CL_SNAN) begin
        anySnan = 1'b1;
        snanIdx = IDX_W'(i);
      end
      if (opClass[i] == CL_QNAN) begin
        anyQnan = 1'b1;
        qnanIdx = IDX_W'(i);
      end
    end
  end

  assign prodSign     = opSign[IX] ^ opSign[IY] ^ negProd;
  assign xInf         = opClass[IX] == CL_INF;
  assign yInf         = opClass[IY] == CL_INF;
  assign xZero        = opClass[IX] == CL_ZERO;
  assign yZero        = opClass[IY] == CL_ZERO;
  assign zInf         = opClass[IZ] == CL_INF;
  assign zZero        = opClass[IZ] == CL_ZERO;
  assign infTimesZero = (xInf & yZero) | (xZero & yInf);
  assign prodInf      = (xInf | yInf) & ~infTimesZero;
  assign prodZero     = (xZero | yZero) & ~infTimesZero;

  always_comb begin
    strobe = '0;
    if (anySnan) begin
      strobe.pickOp       = 1'b1;
      strobe.opIdx        = snanIdx;
      strobe.quietIt      = 1'b1;
      strobe.raiseInvalid = 1'b1;
    end else if (anyQnan) begin
      strobe.pickOp = 1'b1;
      strobe.opIdx  = qnanIdx;
    end else if (infTimesZero) begin
      strobe.pickDefNan   = 1'b1;
      strobe.raiseInvalid = 1'b1;
    end else if (prodInf) begin
      if (zInf && (opSign[IZ] != prodSign)) begin
        strobe.pickDefNan   = 1'b1;
        strobe.raiseInvalid = 1'b1;
      end else begin
        strobe.pickInf = 1'b1;
        strobe.infSign = prodSign;
      end
    end else if (zInf) begin
      strobe.pickOp = 1'b1;
      strobe.opIdx  = IDX_W'(IZ);
    end else if (prodZero) begin
      if (zZero && (opSign[IZ] != prodSign)) begin
        strobe.pickZero = 1'b1;
        strobe.zeroSign = rndMode == RM_DOWN;
      end else begin
        strobe.pickOp = 1'b1;
        strobe.opIdx  = IDX_W'(IZ);
      end
    end
  end
endmodule

// File: rtl/fma_sc_datapath.sv
module fma_sc_datapath
  import fma_sc_pkg::*;
(
  input  logic [WORD_W-1:0] opWord [N_OPS],
  input  strobe_t           strobe,
  output logic [WORD_W-1:0] resultWord,
  output logic              resultValid,
  output logic              invalidOut,
  output logic              proceedOut
);
  localparam logic [WORD_W-1:0] DEF_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] POS_INF =
    {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic [WORD_W-1:0] chosenOp;

  always_comb begin
    chosenOp = opWord[strobe.opIdx];
    if (strobe.quietIt) chosenOp[QBIT] = 1'b1;
  end

  always_comb begin
    resultWord = '0;
    if (strobe.pickOp)          resultWord = chosenOp;
    else if (strobe.pickDefNan) resultWord = DEF_NAN;
    else if (strobe.pickInf)    resultWord = {strobe.infSign, POS_INF[WORD_W-2:0]};
    else if (strobe.pickZero)   resultWord = {strobe.zeroSign, {(WORD_W-1){1'b0}}};
  end

  assign resultValid = strobe.pickOp | strobe.pickDefNan | strobe.pickInf | strobe.pickZero;
  assign invalidOut  = strobe.raiseInvalid;
  assign proceedOut  = ~resultValid;
endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
  import fma_sc_pkg::*;
(
  input  logic [WORD_W-1:0] zOp,
  input  logic [WORD_W-1:0] xOp,
  input  logic [WORD_W-1:0] yOp,
  input  logic              negProd,
  input  logic [1:0]        rndMode,
  output logic              specialValid,
  output logic [WORD_W-1:0] specialResult,
  output logic              invalidFlag,
  output logic              proceed
);
  logic [WORD_W-1:0] opWord  [N_OPS];
  fpClass_e          opClass [N_OPS];
  logic              opSign  [N_OPS];
  strobe_t           strobe;

  assign opWord[0] = zOp;
  assign opWord[1] = xOp;
  assign opWord[2] = yOp;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fma_sc_classify #(.EW(EXP_W), .FW(FRAC_W)) u_cls (
      .opWord (opWord[g]),
      .opClass(opClass[g]),
      .opSign (opSign[g])
    );
  end

  fma_sc_ctrl u_ctrl (
    .opClass(opClass),
    .opSign (opSign),
    .negProd(negProd),
    .rndMode(rndMode),
    .strobe (strobe)
  );

  fma_sc_datapath u_dp (
    .opWord     (opWord),
    .strobe     (strobe),
    .resultWord (specialResult),
    .resultValid(specialValid),
    .invalidOut (invalidFlag),
    .proceedOut (proceed)
  );
endmodule

// File: rtl/fma_sc_checker.sv
module fma_sc_checker
  import fma_sc_pkg::*;
(
  input logic [WORD_W-1:0] zOp,
  input logic [WORD_W-1:0] xOp,
  input logic [WORD_W-1:0] yOp,
  input logic              negProd,
  input logic [1:0]        rndMode,
  input logic              specialValid,
  input logic [WORD_W-1:0] specialResult,
  input logic              invalidFlag,
  input logic              proceed
);
  function automatic logic isNan(logic [WORD_W-1:0] v);
    return (&v[WORD_W-2:FRAC_W]) && (|v[FRAC_W-1:0]);
  endfunction
  function automatic logic isSnan(logic [WORD_W-1:0] v);
    return isNan(v) && !v[QBIT];
  endfunction
  function automatic logic isInf(logic [WORD_W-1:0] v);
    return (&v[WORD_W-2:FRAC_W]) && !(|v[FRAC_W-1:0]);
  endfunction
  function automatic logic isZero(logic [WORD_W-2:0] mag);
    return ~|mag;
  endfunction

  logic anySnan, anyNan, infZero;
  assign anySnan = isSnan(zOp) | isSnan(xOp) | isSnan(yOp);
  assign anyNan  = isNan(zOp) | isNan(xOp) | isNan(yOp);
  assign infZero = (isInf(xOp) & isZero(yOp[WORD_W-2:0])) |
                   (isZero(xOp[WORD_W-2:0]) & isInf(yOp));

  always_comb begin
    a_r11_proceed_excl: assert (proceed != specialValid)
      else $error("proceed and specialValid agree");
    if (proceed) begin
      a_r11_idle_outputs: assert (specialResult == '0 && !invalidFlag)
        else $error("outputs driven while proceeding");
    end
    if (anySnan) begin
      a_r1_snan_quieted: assert (specialValid && invalidFlag && isNan(specialResult) && specialResult[QBIT])
        else $error("signalling NaN not resolved");
    end
    if (anyNan && !anySnan) begin
      a_r2_qnan_quiet: assert (specialValid && !invalidFlag &&
                               (specialResult == zOp || specialResult == xOp || specialResult == yOp))
        else $error("quiet NaN not passed through");
    end
    if (!anyNan && infZero) begin
      a_r3_inf_zero: assert (invalidFlag && specialResult == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}})
        else $error("infinity times zero not invalid");
    end
  end
endmodule

bind fma_special_resolve fma_sc_checker u_chk (.*);

// File: tb/sim_fma_special_resolve.sv
module sim_fma_special_resolve;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [63:0] zOp, xOp, yOp;
  logic        negProd;
  logic [1:0]  rndMode;
  logic        specialValid, invalidFlag, proceed;
  logic [63:0] specialResult;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  fma_special_resolve u0 (.*);

  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;

  // bench class codes: 0 sNaN, 1 qNaN, 2 inf, 3 zero, 4 subnormal, 5 normal
  function automatic int clsOf(logic [63:0] v);
    if (v[62:52] == 11'h7FF) begin
      if (v[51:0] == 0) return 2;
      return v[51] ? 1 : 0;
    end
    if (v[62:52] == 0) return (v[51:0] == 0) ? 3 : 4;
    return 5;
  endfunction

  function automatic logic [63:0] makeOp(int c);
    logic [63:0] v;
    v = {$urandom, $urandom};
    case (c)
      0: begin v[62:52] = 11'h7FF; v[51] = 1'b0; v[0] = 1'b1; end
      1: begin v[62:52] = 11'h7FF; v[51] = 1'b1; end
      2: begin v[62:0] = PINF[62:0]; end
      3: begin v[62:0] = '0; end
      4: begin v[62:52] = '0; v[0] = 1'b1; end
      default: begin
        v[62:52] = 11'($urandom_range(1, 2046));
      end
    endcase
    return v;
  endfunction

  function automatic int pickClass();
    int r = $urandom_range(0, 15);
    if (r == 0) return 0;
    if (r == 1) return 1;
    if (r <= 4) return 2;
    if (r <= 8) return 3;
    if (r <= 10) return 4;
    return 5;
  endfunction

  // reference: returns {valid, invalid, result}
  function automatic logic [65:0] refModel(logic [63:0] z, logic [63:0] x, logic [63:0] y,
                                           logic ng, logic [1:0] rm, output string tag);
    int cz = clsOf(z), cx = clsOf(x), cy = clsOf(y);
    logic ps = x[63] ^ y[63] ^ ng;
    string sTag = ng ? "R4 " : "";
    if (cz == 0) begin tag = "R1"; return {2'b11, z | 64'h0008_0000_0000_0000}; end
    if (cx == 0) begin tag = "R1"; return {2'b11, x | 64'h0008_0000_0000_0000}; end
    if (cy == 0) begin tag = "R1"; return {2'b11, y | 64'h0008_0000_0000_0000}; end
    if (cz == 1) begin tag = "R2"; return {2'b10, z}; end
    if (cx == 1) begin tag = "R2"; return {2'b10, x}; end
    if (cy == 1) begin tag = "R2"; return {2'b10, y}; end
    if ((cx == 2 && cy == 3) || (cx == 3 && cy == 2)) begin
      tag = "R3"; return {2'b11, DNAN};
    end
    if (cx == 2 || cy == 2) begin
      if (cz == 2 && z[63] != ps) begin tag = {sTag, "R5"}; return {2'b11, DNAN}; end
      tag = {sTag, "R6"}; return {2'b10, ps, PINF[62:0]};
    end
    if (cz == 2) begin tag = "R7"; return {2'b10, z}; end
    if (cx == 3 || cy == 3) begin
      if (cz == 3) begin
        if (z[63] == ps) begin tag = {sTag, "R9"}; return {2'b10, z}; end
        tag = {sTag, "R10"}; return {2'b10, (rm == 2'b11), 63'd0};
      end
      tag = "R8"; return {2'b10, z};
    end
    tag = "R11";
    return {2'b00, 64'd0};
  endfunction

  task automatic runVec(logic [63:0] z, logic [63:0] x, logic [63:0] y,
                        logic ng, logic [1:0] rm);
    logic [65:0] exp;
    logic [65:0] act;
    string tag;
    @(posedge clk);
    zOp = z; xOp = x; yOp = y; negProd = ng; rndMode = rm;
    @(negedge clk);
    exp = refModel(z, x, y, ng, rm, tag);
    act = {specialValid, invalidFlag, specialResult};
    total++;
    if (act != exp || proceed != !exp[65]) begin
      bad++;
      $display("FAIL %s z=%h x=%h y=%h neg=%0d rm=%0d actual=%h/%0d expected=%h/%0d",
               tag, z, x, y, ng, rm, act, proceed, exp, !exp[65]);
    end
  endtask

  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] SUBN = 64'h0000_0000_0000_0001;
  localparam logic [63:0] QA   = 64'h7FF8_0000_0000_00AA;
  localparam logic [63:0] QB   = 64'hFFF8_0000_0000_00BB;
  localparam logic [63:0] SA   = 64'h7FF0_0000_0000_0011;
  localparam logic [63:0] SB   = 64'hFFF0_0000_0000_0022;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;

  initial begin
    zOp = '0; xOp = '0; yOp = '0; negProd = 1'b0; rndMode = 2'b00;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // all-zero start state: R9 returns +0
    runVec('0, '0, '0, 1'b0, 2'b00);
    // R1 ordering z, x, y
    runVec(QA, SA, SB, 1'b0, 2'b00);
    runVec(SB, SA, QA, 1'b0, 2'b00);
    runVec(ONE, QA, SB, 1'b0, 2'b00);
    // R2 ordering
    runVec(ONE, QB, QA, 1'b0, 2'b00);
    runVec(QA, QB, ONE, 1'b0, 2'b00);
    // R3 both orders, z infinite
    runVec(NINF, PINF, '0, 1'b0, 2'b00);
    runVec(ONE, NZ, NINF, 1'b1, 2'b00);
    // R5 / R6 with R4 sign inversion
    runVec(NINF, PINF, ONE, 1'b0, 2'b00);
    runVec(NINF, PINF, ONE, 1'b1, 2'b00);
    runVec(PINF, PINF, ONE, 1'b1, 2'b00);
    runVec(ONE, NINF, SUBN, 1'b0, 2'b00);
    // R7
    runVec(NINF, ONE, ONE, 1'b0, 2'b00);
    runVec(PINF, '0, ONE, 1'b1, 2'b00);
    // R8
    runVec(SUBN, '0, ONE, 1'b0, 2'b01);
    // R9 / R10 across rounding modes
    runVec(NZ, NZ, ONE, 1'b0, 2'b11);
    runVec(NZ, '0, ONE, 1'b0, 2'b11);
    runVec(NZ, '0, ONE, 1'b0, 2'b10);
    runVec('0, '0, ONE, 1'b1, 2'b11);
    runVec('0, '0, ONE, 1'b1, 2'b00);
    // R11
    runVec(ONE, ONE, SUBN, 1'b0, 2'b00);
    runVec(SUBN, SUBN, SUBN, 1'b1, 2'b11);
    for (int i = 0; i < 3000; i++) begin
      runVec(makeOp(pickClass()), makeOp(pickClass()), makeOp(pickClass()),
             1'($urandom), 2'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule